// File: doc/BRIEF.md
# Transmit Start Gating Controller

This block tells a MAC transmitter when it may start the preamble of the frame now queued in the transmit FIFO. It watches the FIFO fill level and a flag that says the whole frame has been written into the FIFO. A 2-bit select picks a start threshold in bytes. In the normal mode, reaching that threshold is enough to start. In the safe mode the frame must also be fully buffered, so the transmitter can never run out of data in the middle of a frame.

A frame opens when the FIFO turns non-empty while the block is idle. At that moment the safe-mode bit is captured, and the captured value governs that frame alone. The permission is a registered level. It stays asserted until the MAC reports end of frame, and then the block goes back to idle.

A hard reset clears the mode bit and the permission. A synchronous soft reset does the same. A stop request drops the permission but leaves the programmed mode bit as it was.

Top module: `tx_start_gate`

## Requirements
- R1: After hard reset `start_ok` is 0 and `nouflo_mode` is 0.
- R2: `thr_sel` encodes the start threshold as 0=4, 1=64, 2=128 and 3=256 bytes. With the captured mode 0, an open frame is granted `start_ok`=1 at the first rising edge at which `fifo_level` >= threshold. The frame opens one edge after the FIFO turns non-empty.
- R3: In an open frame, `frame_done`=1 together with a non-zero level qualifies the frame even when the level is below the threshold.
- R4: With the captured mode 1, `start_ok` is granted only at an edge where `frame_done`=1 and the level is non-zero. Meeting the byte threshold alone does not grant it.
- R5: `start_ok` is never granted at an edge where `fifo_level` is 0, even with `frame_done`=1.
- R6: Once granted, `start_ok` stays 1 regardless of level changes until `eof`=1 is sampled. It is 0 after that edge.
- R7: `soft_rst`=1 clears `nouflo_mode` and `start_ok` at the next edge. A mode write in the same cycle loses.
- R8: `stop`=1 clears `start_ok` at the next edge and leaves `nouflo_mode` unchanged.
- R9: The mode bit is captured at the edge where an idle block sees a non-empty FIFO. A mode write after that edge affects only the next frame.
- R10: `cfg_wr`=1 loads `cfg_din` into `nouflo_mode` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| stop | input | 1 | Stop request, drops permission |
| cfg_wr | input | 1 | Mode bit write strobe |
| cfg_din | input | 1 | Mode bit write data |
| thr_sel | input | 2 | Start threshold select |
| fifo_level | input | 10 | Transmit FIFO fill level in bytes |
| frame_done | input | 1 | Whole frame is in the FIFO |
| eof | input | 1 | MAC end of frame |
| start_ok | output | 1 | Preamble start permission |
| nouflo_mode | output | 1 | Programmed safe-mode bit |

## Verification
Two pairs of events can fall in the same cycle. The first pair is end of frame and the first bytes of the next frame: `eof` is raised while the FIFO level is still non-zero. The check is that permission drops for at least one cycle, and that the next frame then opens and is granted under its own rules. The second pair is a soft reset and a mode write in the same cycle, where the expected outcome is a cleared mode bit. Random traffic with rare stops, soft resets and writes also lands these events on the same edges, and a bench model of the requirements judges every cycle.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
   typedef enum logic [1:0] {
      GS_IDLE = 2'd0,
      GS_WAIT = 2'd1,
      GS_SEND = 2'd2
   } gate_st_e;

   localparam int unsigned NUM_THR = 4;
endpackage

// File: rtl/tsg_thr_decode.sv
module tsg_thr_decode #(
   parameter int unsigned LVL_W      = 10,
   parameter int unsigned FIFO_DEPTH = 512,
   parameter int unsigned THR0       = 4,
   parameter int unsigned THR1       = 64,
   parameter int unsigned THR2       = 128,
   parameter int unsigned THR3       = 256,
   parameter bit          TOP_WHOLE  = 1'b0
) (
   input  logic [1:0]       thr_sel,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             frame_done,
   output logic             thr_met
);
   import tsg_pkg::*;

   localparam int unsigned THR_TAB [NUM_THR] = '{THR0, THR1, THR2, THR3};

   logic [NUM_THR-1:0] hit;

   if (THR0 == 0) begin : g_bad_zero
      $error("tsg_thr_decode: threshold 0 must be non-zero");
   end
   if (!(THR0 <= THR1 && THR1 <= THR2 && THR2 <= THR3)) begin : g_bad_order
      $error("tsg_thr_decode: thresholds must ascend");
   end
   if (THR3 > FIFO_DEPTH) begin : g_bad_depth
      $error("tsg_thr_decode: threshold exceeds FIFO depth");
   end

   for (genvar i = 0; i < NUM_THR; i++) begin : g_cmp
      if (i == NUM_THR - 1 && TOP_WHOLE) begin : g_whole
         assign hit[i] = 1'b0;
      end else begin : g_level
         assign hit[i] = 32'(fifo_level) >= THR_TAB[i];
      end
   end

   assign thr_met = hit[thr_sel] | frame_done;
endmodule

// File: rtl/tsg_mode_reg.sv
module tsg_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic wr,
   input  logic din,
   output logic mode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= 1'b0;
      else if (soft_rst) mode_q <= 1'b0;
      else if (wr)       mode_q <= din;
   end

   a_r7_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !mode_q);

   a_r10_write_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !soft_rst) |=> (mode_q == $past(din)));

   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !soft_rst) |=> $stable(mode_q));
endmodule

// File: rtl/tsg_gate_fsm.sv
module tsg_gate_fsm #(
   parameter int unsigned LVL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             stop,
   input  logic             mode_q,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             frame_done,
   input  logic             thr_met,
   input  logic             eof,
   output logic             start_ok
);
   import tsg_pkg::*;

   gate_st_e st_q, st_d;
   logic     eff_q;
   logic     non_empty;
   logic     go;

   assign non_empty = |fifo_level;
   assign go        = non_empty && thr_met && (!eff_q || frame_done);

   always_comb begin
      st_d = st_q;
      if (soft_rst || stop) begin
         st_d = GS_IDLE;
      end else begin
         case (st_q)
            GS_IDLE: if (non_empty) st_d = GS_WAIT;
            GS_WAIT: if (go)        st_d = GS_SEND;
            GS_SEND: if (eof)       st_d = GS_IDLE;
            default:                st_d = GS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= GS_IDLE;
         eff_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == GS_IDLE && non_empty && !soft_rst && !stop) eff_q <= mode_q;
      end
   end

   assign start_ok = (st_q == GS_SEND);

   a_r5_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_ok) |-> ($past(fifo_level) != '0));

   a_r4_whole_frame: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start_ok) && $past(eff_q)) |-> $past(frame_done));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && !eof && !stop && !soft_rst) |=> start_ok);

   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && eof) |=> !start_ok);

   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != GS_IDLE && $past(st_q != GS_IDLE)) |-> $stable(eff_q));
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
   parameter int unsigned FIFO_DEPTH = 512,
   parameter int unsigned THR0       = 4,
   parameter int unsigned THR1       = 64,
   parameter int unsigned THR2       = 128,
   parameter int unsigned THR3       = 256,
   parameter bit          TOP_WHOLE  = 1'b0,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             stop,
   input  logic             cfg_wr,
   input  logic             cfg_din,
   input  logic [1:0]       thr_sel,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             frame_done,
   input  logic             eof,
   output logic             start_ok,
   output logic             nouflo_mode
);
   logic thr_met;

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("tx_start_gate: FIFO_DEPTH too small");
   end

   tsg_thr_decode #(
      .LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH),
      .THR0(THR0), .THR1(THR1), .THR2(THR2), .THR3(THR3),
      .TOP_WHOLE(TOP_WHOLE)
   ) u_thr (
      .thr_sel(thr_sel),
      .fifo_level(fifo_level),
      .frame_done(frame_done),
      .thr_met(thr_met)
   );

   tsg_mode_reg u_mode (
      .clk(clk),
      .rst_n(rst_n),
      .soft_rst(soft_rst),
      .wr(cfg_wr),
      .din(cfg_din),
      .mode_q(nouflo_mode)
   );

   tsg_gate_fsm #(.LVL_W(LVL_W)) u_fsm (
      .clk(clk),
      .rst_n(rst_n),
      .soft_rst(soft_rst),
      .stop(stop),
      .mode_q(nouflo_mode),
      .fifo_level(fifo_level),
      .frame_done(frame_done),
      .thr_met(thr_met),
      .eof(eof),
      .start_ok(start_ok)
   );

   a_r8_stop_drop: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !start_ok);

   a_r8_stop_keep_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !soft_rst && !cfg_wr) |=> $stable(nouflo_mode));

   a_r7_soft_drop: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !start_ok);
endmodule

// File: tb/tb_tx_start_gate.sv
module tb_tx_start_gate;
   logic       clk = 1'b0;
   logic       rst_n, soft_rst, stop, cfg_wr, cfg_din, frame_done, eof;
   logic [1:0] thr_sel;
   logic [9:0] fifo_level;
   logic       start_ok, nouflo_mode;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   int m_st;
   bit m_eff, m_mode;

   always #5 clk = ~clk;

   tx_start_gate dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
      .cfg_wr(cfg_wr), .cfg_din(cfg_din), .thr_sel(thr_sel),
      .fifo_level(fifo_level), .frame_done(frame_done), .eof(eof),
      .start_ok(start_ok), .nouflo_mode(nouflo_mode)
   );

   function automatic int thr_of(input logic [1:0] s);
      case (s)
         2'd0: return 4;
         2'd1: return 64;
         2'd2: return 128;
         default: return 256;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic model_step();
      bit ne, go, old_mode;
      ne = (fifo_level != 0);
      go = ne && ((int'(fifo_level) >= thr_of(thr_sel)) || frame_done) && (!m_eff || frame_done);
      old_mode = m_mode;
      if (soft_rst) begin
         m_mode = 1'b0;
         m_st = 0;
      end else begin
         if (cfg_wr) m_mode = cfg_din;
         if (stop) m_st = 0;
         else case (m_st)
            0: if (ne) begin m_st = 1; m_eff = old_mode; end
            1: if (go) m_st = 2;
            default: if (eof) m_st = 0;
         endcase
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_step();
      #1;
      check(tag, "start_ok model", int'(start_ok), int'(m_st == 2));
      check(tag, "mode model", int'(nouflo_mode), int'(m_mode));
   endtask

   task automatic quiet();
      soft_rst = 0; stop = 0; cfg_wr = 0; cfg_din = 0;
      frame_done = 0; eof = 0; fifo_level = 0;
   endtask

   task automatic close_frame(input string tag);
      eof = 1; tick(tag);
      eof = 0; fifo_level = 0; frame_done = 0; tick(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got timeout expected finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      quiet(); thr_sel = 0; rst_n = 0;
      m_st = 0; m_eff = 0; m_mode = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
      check("R1", "start_ok after reset", int'(start_ok), 0);
      check("R1", "mode after reset", int'(nouflo_mode), 0);

      // R2: threshold 64, mode 0
      thr_sel = 1; fifo_level = 63; tick("R2");
      tick("R2");
      check("R2", "below 64", int'(start_ok), 0);
      fifo_level = 64; tick("R2");
      check("R2", "at 64", int'(start_ok), 1);
      // R6: level drop keeps permission, eof releases
      fifo_level = 10; tick("R6");
      check("R6", "held after level drop", int'(start_ok), 1);
      eof = 1; tick("R6");
      check("R6", "released by eof", int'(start_ok), 0);
      eof = 0; fifo_level = 0; tick("R6");

      // R5: frame_done with empty FIFO
      frame_done = 1; tick("R5"); tick("R5"); tick("R5");
      check("R5", "empty fifo", int'(start_ok), 0);
      frame_done = 0;

      // R3: short complete frame under threshold 256
      thr_sel = 3; fifo_level = 20; tick("R3"); tick("R3");
      check("R3", "short incomplete", int'(start_ok), 0);
      frame_done = 1; tick("R3");
      check("R3", "short complete", int'(start_ok), 1);
      close_frame("R3");

      // R10 + R4: safe mode requires whole frame
      cfg_wr = 1; cfg_din = 1; tick("R10");
      cfg_wr = 0; cfg_din = 0;
      check("R10", "mode written", int'(nouflo_mode), 1);
      thr_sel = 0; fifo_level = 300; tick("R4"); tick("R4"); tick("R4");
      check("R4", "threshold only", int'(start_ok), 0);
      frame_done = 1; tick("R4");
      check("R4", "whole frame", int'(start_ok), 1);
      close_frame("R4");

      // R9: mid-frame mode change applies to next frame
      fifo_level = 5; tick("R9");
      cfg_wr = 1; cfg_din = 0; tick("R9");
      cfg_wr = 0; fifo_level = 100; tick("R9");
      check("R9", "old mode still gates", int'(start_ok), 0);
      frame_done = 1; tick("R9");
      check("R9", "granted on complete", int'(start_ok), 1);
      close_frame("R9");
      fifo_level = 100; tick("R9"); tick("R9");
      check("R9", "new mode next frame", int'(start_ok), 1);
      // collision: eof with next frame data present
      eof = 1; fifo_level = 200; tick("R6");
      check("R6", "eof with data", int'(start_ok), 0);
      eof = 0; tick("R6");
      check("R6", "reopen wait", int'(start_ok), 0);
      tick("R2");
      check("R2", "next frame granted", int'(start_ok), 1);

      // R8: stop drops permission, keeps mode
      cfg_wr = 1; cfg_din = 1; tick("R8");
      cfg_wr = 0; stop = 1; tick("R8");
      check("R8", "stop drops", int'(start_ok), 0);
      check("R8", "stop keeps mode", int'(nouflo_mode), 1);
      stop = 0; fifo_level = 0; tick("R8");

      // R7: soft reset vs write in same cycle
      fifo_level = 50; frame_done = 1; tick("R7"); tick("R7");
      check("R7", "granted before soft", int'(start_ok), 1);
      soft_rst = 1; cfg_wr = 1; cfg_din = 1; tick("R7");
      check("R7", "soft clears mode", int'(nouflo_mode), 0);
      check("R7", "soft clears grant", int'(start_ok), 0);
      quiet(); tick("R7");

      // random traffic
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 4000; i++) begin
         soft_rst   = ($urandom % 200) == 0;
         stop       = ($urandom % 150) == 0;
         cfg_wr     = ($urandom % 40) == 0;
         cfg_din    = $urandom % 2;
         thr_sel    = 2'($urandom % 4);
         if (($urandom % 6) == 0) fifo_level = 10'($urandom % 8);
         else if (($urandom % 3) == 0) fifo_level = 10'($urandom % 512);
         frame_done = ($urandom % 5) == 0;
         eof        = ($urandom % 12) == 0;
         tick("R2 R4 random");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule